// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a serial chain of boundary cells placed between the core logic and the device pins. There are three kinds of cell. Input cells observe the pins. Output-enable cells each control a group of output pins. Output data cells each drive one pin. Every cell has a shift stage, which can be loaded in parallel or shifted by one position. Enable cells and output data cells also have a shadow stage, which is loaded only on an update strobe. An external test controller supplies the capture, shift and update strobes on the test clock. An instruction decoder supplies a two-bit mode.

In normal mode the core drives the pins directly through combinational paths. In external-test and clamp modes the shadow stages drive the pins, so the pin values stay fixed while new patterns are shifted through the chain. In high-impedance mode every output enable is forced off. An asynchronous active-low test reset clears the chain and returns the pins to normal operation.

Top module: `bscan_chain`

## Requirements
- R1: With mode 0 (normal), `pin_out` equals `core_out` and each `pin_oe[i]` equals `core_oe[i / (N_OUT/N_GRP)]`, with no clock delay.
- R2: On a rising `tck` with `capture_en` high, the chain parallel-loads the vector `{core_out, core_oe, pin_in}`.
- R3: On a rising `tck` with `shift_en` high and `capture_en` low, every bit moves one cell toward `tdo`. `tdi` enters the cell furthest from `tdo`, and `tdo` shows the nearest cell.
- R4: With `capture_en` and `shift_en` both low, a rising `tck` leaves the chain, and therefore `tdo`, unchanged.
- R5: The shadow stages keep their value during capture and shift. On a rising `tck` with `update_en` high they load the enable and data part of the chain.
- R6: With mode 1 (external test), `pin_out` comes from the data shadows and `pin_oe` comes from the shadow of the group's enable cell.
- R7: With mode 2 (clamp), the outputs are driven from the shadow stages in the same way as in mode 1.
- R8: With mode 3 (high impedance), every `pin_oe` bit is 0.
- R9: While `trst_n` is low, the chain and the shadows are cleared and the outputs behave as in mode 0, whatever `mode` is.
- R10: When `capture_en` and `shift_en` are both high, capture takes priority.
- R11: `core_in` always equals `pin_in`, in every mode.
- R12: Serial order from `tdo`: first `pin_in[0]` through `pin_in[N_IN-1]`, then `core_oe` from bit 0 upward, then `core_out` from bit 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_en | input | 1 | Parallel-load strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Shadow load strobe |
| mode | input | 2 | 0 normal, 1 external test, 2 clamp, 3 high impedance |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pin_in | input | N_IN | Values at the input pins |
| core_in | output | N_IN | Input values passed to the core |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_GRP | Output enables from the core, one per group |
| pin_out | output | N_OUT | Data driven to the output pins |
| pin_oe | output | N_OUT | Enable for each output pin |

## Verification
The hardest case to reach is a frozen pin pattern while a different pattern is shifted through the chain. To get there, the shadows must first be loaded through a complete serial pass and an update. A second pass then has to run in a test mode with no update. The stimulus does this with directed shift-in sequences and then checks the pins before and after the update strobe. Random sequences of capture, shift, update and hold, run in random modes, then compare `tdo` and the pins against a bench model of the chain and the shadows. This also covers simultaneous capture and shift, and a reset applied in the middle of a test.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 8,
  parameter int N_GRP = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic [1:0]       mode,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_oe,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  localparam int LEN = N_IN + N_GRP + N_OUT;
  localparam int NSH = N_GRP + N_OUT;
  localparam int GW  = N_OUT / N_GRP;
  localparam logic [1:0] M_NORM = 2'd0;
  localparam logic [1:0] M_HIZ  = 2'd3;

  logic [LEN-1:0]   chain;
  logic [NSH-1:0]   shadow;
  logic [N_GRP-1:0] grp_oe;
  logic [1:0]       eff_mode;
  logic             test_drv;

  assign eff_mode = trst_n ? mode : M_NORM;
  assign test_drv = (eff_mode != M_NORM);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)         chain <= '0;
    else if (capture_en) chain <= {core_out, core_oe, pin_in};
    else if (shift_en)   chain <= {tdi, chain[LEN-1:1]};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)        shadow <= '0;
    else if (update_en) shadow <= chain[LEN-1:N_IN];

  assign tdo     = chain[0];
  assign core_in = pin_in;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_oe[g] = (eff_mode == M_HIZ) ? 1'b0 :
                       test_drv ? shadow[g] : core_oe[g];
    for (genvar b = 0; b < GW; b++) begin : g_bit
      assign pin_out[g*GW+b] = test_drv ? shadow[N_GRP+g*GW+b] : core_out[g*GW+b];
      assign pin_oe[g*GW+b]  = grp_oe[g];
    end
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 8,
  parameter int N_GRP = 2
) (
  input logic                         tck,
  input logic                         trst_n,
  input logic                         capture_en,
  input logic                         shift_en,
  input logic                         update_en,
  input logic [1:0]                   mode,
  input logic                         tdi,
  input logic [N_IN-1:0]              pin_in,
  input logic [N_OUT-1:0]             core_out,
  input logic [N_GRP-1:0]             core_oe,
  input logic [N_OUT-1:0]             pin_oe,
  input logic [N_IN+N_GRP+N_OUT-1:0]  chain,
  input logic [N_GRP+N_OUT-1:0]       shadow
);
  localparam int LEN = N_IN + N_GRP + N_OUT;

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    capture_en |=> chain == $past({core_out, core_oe, pin_in})); // R2
  AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !capture_en) |=> chain[LEN-1] == $past(tdi)); // R3
  AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !capture_en) |=> chain[LEN-2:0] == $past(chain[LEN-1:1])); // R3
  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_en && !capture_en) |=> $stable(chain)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !update_en |=> $stable(shadow)); // R5
  AST_SHADOW_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    update_en |=> shadow == $past(chain[LEN-1:N_IN])); // R5
  AST_RESET_CLEAR: assert property (@(posedge tck)
    !trst_n |-> (shadow == '0 && chain == '0)); // R9
  AST_HIZ_OFF: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'd3) |-> pin_oe == '0); // R8
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_GRP(N_GRP)) u_chk (
  .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
  .update_en(update_en), .mode(mode), .tdi(tdi), .pin_in(pin_in),
  .core_out(core_out), .core_oe(core_oe), .pin_oe(pin_oe),
  .chain(chain), .shadow(shadow)
);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int P     = 10;
  localparam int N_IN  = 4;
  localparam int N_OUT = 8;
  localparam int N_GRP = 2;
  localparam int LEN   = N_IN + N_GRP + N_OUT;
  localparam int NSH   = N_GRP + N_OUT;
  localparam int GW    = N_OUT / N_GRP;

  logic tck = 1'b0, trst_n = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [N_IN-1:0] pin_in = '0, core_in;
  logic [N_OUT-1:0] core_out = '0, pin_out, pin_oe;
  logic [N_GRP-1:0] core_oe = '0;
  logic tdo;

  logic [LEN-1:0] m_chain = '0;
  logic [NSH-1:0] m_sh = '0;
  int n_chk = 0, n_bad = 0;

  always #(P/2) tck = ~tck;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .N_GRP(N_GRP)) i_bscan_chain (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .mode(mode), .tdi(tdi), .tdo(tdo), .pin_in(pin_in),
    .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N_OUT-1:0] exp_out(input logic [1:0] m);
    return (m == 2'd0) ? core_out : m_sh[NSH-1:N_GRP];
  endfunction

  function automatic logic [N_OUT-1:0] exp_oe(input logic [1:0] m);
    logic [N_OUT-1:0] r;
    for (int i = 0; i < N_OUT; i++)
      r[i] = (m == 2'd3) ? 1'b0 : (m == 2'd0) ? core_oe[i/GW] : m_sh[i/GW];
    return r;
  endfunction

  task automatic check_all();
    logic [1:0] em;
    string t;
    em = trst_n ? mode : 2'd0;
    t = (em == 2'd0) ? (trst_n ? "R1" : "R9") : (em == 2'd1) ? "R6" : (em == 2'd2) ? "R7" : "R8";
    chk(t, 32'(pin_out), 32'(exp_out(em)));
    chk(t, 32'(pin_oe), 32'(exp_oe(em)));
    chk("R11", 32'(core_in), 32'(pin_in));
    chk("R3", 32'(tdo), 32'(m_chain[0]));
  endtask

  task automatic step(input logic c, input logic s, input logic u, input logic [1:0] m,
                      input logic d, input logic [N_OUT-1:0] co,
                      input logic [N_GRP-1:0] oe, input logic [N_IN-1:0] pi);
    logic [LEN-1:0] old;
    capture_en = c; shift_en = s; update_en = u; mode = m; tdi = d;
    core_out = co; core_oe = oe; pin_in = pi;
    #(P/4);
    check_all();
    @(posedge tck);
    old = m_chain;
    if (c) m_chain = {co, oe, pi};
    else if (s) m_chain = {d, old[LEN-1:1]};
    if (u) m_sh = old[LEN-1:N_IN];
    @(negedge tck);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(P*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [LEN-1:0] got, v;
    void'($urandom(32'd20240611));
    mode = 2'd1; core_out = 8'h5A; core_oe = 2'b10; pin_in = 4'h6;
    #(P/4);
    // reset state: test mode ignored, outputs from core
    chk("R9", 32'(pin_out), 32'h5A);
    chk("R9", 32'(pin_oe), 32'hF0);
    chk("R9", 32'(tdo), 32'h0);
    @(negedge tck); @(negedge tck);
    trst_n = 1'b1;
    @(negedge tck);

    // capture then unload: order and capture contents
    step(1, 0, 0, 2'd0, 0, 8'hA5, 2'b10, 4'b1011);
    for (int k = 0; k < LEN; k++) begin
      got[k] = tdo;
      step(0, 1, 0, 2'd0, 0, 8'h00, 2'b00, 4'h0);
    end
    chk("R12", 32'(got), 32'({8'hA5, 2'b10, 4'b1011}));
    chk("R2", 32'(got[LEN-1:N_IN]), 32'({8'hA5, 2'b10}));

    // shift a pattern in under external test, pins frozen until update
    v = {8'h3C, 2'b01, 4'h0};
    for (int k = 0; k < LEN; k++) step(0, 1, 0, 2'd1, v[k], 8'hFF, 2'b11, 4'h0);
    #(P/4);
    chk("R5", 32'(pin_out), 32'h00);
    step(0, 0, 1, 2'd1, 0, 8'hFF, 2'b11, 4'h0);
    #(P/4);
    chk("R6", 32'(pin_out), 32'h3C);
    chk("R6", 32'(pin_oe), 32'h0F);
    mode = 2'd2; #1;
    chk("R7", 32'(pin_out), 32'h3C);
    chk("R7", 32'(pin_oe), 32'h0F);
    mode = 2'd3; #1;
    chk("R8", 32'(pin_oe), 32'h00);
    mode = 2'd0; #1;
    chk("R1", 32'(pin_out), 32'hFF);
    chk("R1", 32'(pin_oe), 32'hFF);
    @(negedge tck);

    // shift in new data without update: shadow keeps old pattern
    for (int k = 0; k < LEN; k++) step(0, 1, 0, 2'd1, 1'b1, 8'h00, 2'b00, 4'h0);
    #(P/4);
    chk("R5", 32'(pin_out), 32'h3C);
    @(negedge tck);

    // capture wins over shift
    step(0, 1, 0, 2'd0, 0, 8'h00, 2'b00, 4'h0);
    step(1, 1, 0, 2'd0, 0, 8'h00, 2'b00, 4'b0001);
    #(P/4);
    chk("R10", 32'(tdo), 32'h1);
    @(negedge tck);
    // hold leaves tdo unchanged
    step(0, 0, 0, 2'd0, 1, 8'h00, 2'b00, 4'h0);
    #(P/4);
    chk("R4", 32'(tdo), 32'h1);
    @(negedge tck);

    // reset in mid test
    mode = 2'd1; trst_n = 1'b0; m_chain = '0; m_sh = '0;
    #(P/4);
    chk("R9", 32'(pin_out), 32'(core_out));
    @(negedge tck);
    trst_n = 1'b1;
    #(P/4);
    chk("R9", 32'(pin_out), 32'h00);
    chk("R9", 32'(tdo), 32'h0);
    @(negedge tck);

    // random sequences against the model
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (r == 4'd0) begin
        trst_n = 1'b0; m_chain = '0; m_sh = '0;
        #(P/4); check_all();
        @(negedge tck); trst_n = 1'b1;
      end else begin
        step(r[1:0] == 2'd1 || r == 4'd15, r[3:2] != 2'd0, r[1:0] == 2'd2,
             2'($urandom), 1'($urandom), N_OUT'($urandom), N_GRP'($urandom),
             N_IN'($urandom));
      end
    end
    finish_run();
  end
endmodule